// File: doc/BRIEF.md
# Square-Wave Interval Timer with Twofold Countdown

This block divides an external, slow reference input (`timerIn`) by a programmable length and drives a single output, `timerOut`. The output is either a square wave or a one-period low pulse, and it can fire once or repeat. The reference input is brought into the system clock domain through a synchronizer. Only its falling edges are counted. The count runs downward in steps of two. Each output period is made of two half-cycles, so the register content always moves by two per counted edge, and an odd length makes the high half one input period longer than the low half.

Software programs a 16-bit length word through two byte strobes, then starts and stops the timer with a 2-bit command. A sticky terminal-count flag is raised at the end of every output period. The surrounding bus logic reads that flag and clears it through a dedicated input. Reset halts the timer and clears the flag. It leaves the length word as it was, so nothing counts again until a start command arrives.

Top module: `sqw_timer`

## Requirements
- R1: The length word is 16 bits. A low-byte write loads length bits 7:0. A high-byte write loads length bits 13:8 from data bits 5:0 and the mode from data bits 7:6. Data bit 7 selects pulse output and data bit 6 selects automatic reload.
- R2: A start command (11) given while idle with a length of at least 2 begins counting at once, with the output high. For length 2 in square mode, the output is low after the first counted falling edge.
- R3: In square mode, a length N gives an output that is high for ceil(N/2) input periods and then low for floor(N/2) periods, counted between detected falling edges of `timerIn`.
- R4: Mode 00 produces one square period. After the terminal count the output stays high and the timer is idle.
- R5: Mode 01 reloads the length at each terminal count and repeats the square wave without a gap.
- R6: In the pulse modes (10 single, 11 repeating), the output is low only during the last input period before each terminal count and high otherwise. Mode 10 stops after one pulse.
- R7: Command 01 halts a running timer immediately and the output goes high. Command 00 has no effect on a running count.
- R8: Command 10 lets the current period finish and then halts at its terminal count.
- R9: A start command given while running takes effect at the next terminal count, using the length word as it stands then.
- R10: Writing the length bytes while running does not change the running count or mode until a start command is applied.
- R11: A start command with a programmed length below 2 is ignored. The output stays high and no terminal count occurs.
- R12: The flag `tcFlag` goes high at each terminal count and stays high until `flagClr` is pulsed. A terminal count in the same cycle as the clear wins.
- R13: After reset the output is high and the flag is low. Falling edges on `timerIn` do nothing until a start command is given.
- R14: The count advances only on synchronized falling edges of `timerIn`. While `timerIn` is held steady, a running timer's output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerIn | input | 1 | Asynchronous reference input; falling edges are counted |
| lenLoWr | input | 1 | Strobe: load length bits 7:0 from wrData |
| lenHiWr | input | 1 | Strobe: load length bits 13:8 and mode from wrData |
| wrData | input | 8 | Byte for the length word |
| cmdWr | input | 1 | Strobe: apply cmd |
| cmd | input | 2 | 00 none, 01 halt now, 10 halt at terminal count, 11 start |
| flagClr | input | 1 | Clear the terminal-count flag |
| timerOut | output | 1 | Square wave or pulse output, high when idle |
| tcFlag | output | 1 | Sticky terminal-count flag |

## Verification
A corrupted count or half-cycle marker shows up on `timerOut` no later than the next counted falling edge. The high and low runs lose their expected lengths at once, and the terminal count, together with the flag, arrives at the wrong edge. A stale pending start or pending halt only shows up at the next terminal count, when the following period uses the wrong length or mode, or the timer halts or fails to halt. The bench therefore samples the output once per input period, over several full periods and across every terminal count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_START   = 2'b11
  } timerCmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startLoad;   // copy length word into active copy, load high half
    logic reloadHigh;  // reload high half from active length
    logic loadLow;     // load low half from active length
    logic step;        // count down by two
  } dpCtrl_t;

endpackage

// File: rtl/sqw_edge.sv
module sqw_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic fallEdge
);
  logic [STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[STAGES-1:0], asyncIn};
  end

  assign fallEdge = syncQ[STAGES] & ~syncQ[STAGES-1];
endmodule

// File: rtl/sqw_datapath.sv
module sqw_datapath
  import sqw_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lenLoWr,
  input  logic             lenHiWr,
  input  logic [7:0]       wrData,
  input  dpCtrl_t          dpCtrl,
  output logic             lenValid,
  output logic             cntAtTerm,
  output logic             modeCont,
  output logic             modePulse,
  output logic [LEN_W:0]   cntVal
);
  localparam int REG_W = LEN_W + 2;
  localparam int CNT_W = LEN_W + 1;
  localparam int HI_W  = REG_W - 8;

  logic [REG_W-1:0] lenReg;
  logic [LEN_W-1:0] actLen;
  logic [1:0]       actMode;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] roundUp(input logic [LEN_W-1:0] n);
    return {1'b0, n} + CNT_W'(n[0]);
  endfunction

  function automatic logic [CNT_W-1:0] roundDown(input logic [LEN_W-1:0] n);
    return {1'b0, n[LEN_W-1:1], 1'b0};
  endfunction

  // Length word keeps its value across reset
  always_ff @(posedge clk) begin
    if (lenLoWr) lenReg[7:0]       <= wrData;
    if (lenHiWr) lenReg[REG_W-1:8] <= wrData[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLen  <= '0;
      actMode <= '0;
      cnt     <= '0;
    end else if (dpCtrl.startLoad) begin
      actLen  <= lenReg[LEN_W-1:0];
      actMode <= lenReg[REG_W-1:REG_W-2];
      cnt     <= roundUp(lenReg[LEN_W-1:0]);
    end else if (dpCtrl.reloadHigh) begin
      cnt <= roundUp(actLen);
    end else if (dpCtrl.loadLow) begin
      cnt <= roundDown(actLen);
    end else if (dpCtrl.step) begin
      cnt <= cnt - CNT_W'(2);
    end
  end

  assign lenValid  = |lenReg[LEN_W-1:1];
  assign cntAtTerm = (cnt == CNT_W'(2));
  assign modeCont  = actMode[0];
  assign modePulse = actMode[1];
  assign cntVal    = cnt;
endmodule

// File: rtl/sqw_control.sv
module sqw_control
  import sqw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fallEdge,
  input  logic    cmdWr,
  input  logic [1:0] cmd,
  input  logic    flagClr,
  input  logic    lenValid,
  input  logic    cntAtTerm,
  input  logic    modeCont,
  input  logic    modePulse,
  output dpCtrl_t dpCtrl,
  output logic    running,
  output logic    timerOut,
  output logic    tcFlag
);
  logic lowHalf, pending, haltAtTc;
  logic runNext, lowNext, pendNext, haltNext, flagSet;

  always_comb begin
    dpCtrl   = '0;
    runNext  = running;
    lowNext  = lowHalf;
    pendNext = pending;
    haltNext = haltAtTc;
    flagSet  = 1'b0;

    if (running && fallEdge) begin
      if (!cntAtTerm) begin
        dpCtrl.step = 1'b1;
      end else if (!lowHalf) begin
        dpCtrl.loadLow = 1'b1;
        lowNext        = 1'b1;
      end else begin
        flagSet  = 1'b1;
        lowNext  = 1'b0;
        pendNext = 1'b0;
        haltNext = 1'b0;
        if (pending) begin
          if (lenValid) dpCtrl.startLoad = 1'b1;
          else          runNext = 1'b0;
        end else if (haltAtTc) begin
          runNext = 1'b0;
        end else if (modeCont) begin
          dpCtrl.reloadHigh = 1'b1;
        end else begin
          runNext = 1'b0;
        end
      end
    end

    if (cmdWr) begin
      case (cmd)
        CMD_HALT: runNext = 1'b0;
        CMD_HALT_TC: begin
          if (runNext) begin
            haltNext = 1'b1;
            pendNext = 1'b0;
          end
        end
        CMD_START: begin
          if (!runNext) begin
            if (lenValid) begin
              dpCtrl           = '0;
              dpCtrl.startLoad = 1'b1;
              runNext          = 1'b1;
              lowNext          = 1'b0;
            end
          end else begin
            pendNext = 1'b1;
            haltNext = 1'b0;
          end
        end
        default: ;
      endcase
    end

    if (!runNext) begin
      lowNext  = 1'b0;
      pendNext = 1'b0;
      haltNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      lowHalf  <= 1'b0;
      pending  <= 1'b0;
      haltAtTc <= 1'b0;
      tcFlag   <= 1'b0;
    end else begin
      running  <= runNext;
      lowHalf  <= lowNext;
      pending  <= pendNext;
      haltAtTc <= haltNext;
      if (flagSet)      tcFlag <= 1'b1;
      else if (flagClr) tcFlag <= 1'b0;
    end
  end

  assign timerOut = modePulse ? ~(running & lowHalf & cntAtTerm)
                              : ~(running & lowHalf);
endmodule

// File: rtl/sqw_timer.sv
module sqw_timer
  import sqw_pkg::*;
#(
  parameter int LEN_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerIn,
  input  logic       lenLoWr,
  input  logic       lenHiWr,
  input  logic [7:0] wrData,
  input  logic       cmdWr,
  input  logic [1:0] cmd,
  input  logic       flagClr,
  output logic       timerOut,
  output logic       tcFlag
);
  dpCtrl_t        dpCtrl;
  logic           fallEdge, running;
  logic           lenValid, cntAtTerm, modeCont, modePulse;
  logic [LEN_W:0] cntVal;

  sqw_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rstN(rstN), .asyncIn(timerIn), .fallEdge(fallEdge)
  );

  sqw_datapath #(.LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .lenLoWr(lenLoWr), .lenHiWr(lenHiWr),
    .wrData(wrData), .dpCtrl(dpCtrl), .lenValid(lenValid),
    .cntAtTerm(cntAtTerm), .modeCont(modeCont), .modePulse(modePulse),
    .cntVal(cntVal)
  );

  sqw_control i_ctl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .cmdWr(cmdWr), .cmd(cmd),
    .flagClr(flagClr), .lenValid(lenValid), .cntAtTerm(cntAtTerm),
    .modeCont(modeCont), .modePulse(modePulse), .dpCtrl(dpCtrl),
    .running(running), .timerOut(timerOut), .tcFlag(tcFlag)
  );
endmodule

// File: rtl/sqw_timer_chk.sv
module sqw_timer_chk #(
  parameter int LEN_W = 14
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdWr,
  input logic [1:0]     cmd,
  input logic           flagClr,
  input logic           timerOut,
  input logic           tcFlag,
  input logic           fallEdge,
  input logic           running,
  input logic [LEN_W:0] cntVal
);
  // R12: flag holds until cleared
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    tcFlag && !flagClr |=> tcFlag);

  // R12: flag only rises on a counted edge of a running timer
  p_flag_rise_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcFlag) |-> $past(running && fallEdge));

  // R7: halt command idles the timer with output high
  p_halt_now_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmd == 2'b01 |=> !running && timerOut);

  // R3: a running count never drops under the terminal value
  p_cnt_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> cntVal >= 2);

  // R14: output moves only after a counted edge or a command
  p_out_on_event_r14: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(timerOut) |-> $past(fallEdge) || $past(cmdWr));
endmodule

bind sqw_timer sqw_timer_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmd(cmd), .flagClr(flagClr),
  .timerOut(timerOut), .tcFlag(tcFlag), .fallEdge(fallEdge),
  .running(running), .cntVal(cntVal)
);

// File: tb/test_sqw_timer.sv
module test_sqw_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timerIn = 1'b1;
  logic       lenLoWr = 1'b0, lenHiWr = 1'b0, cmdWr = 1'b0, flagClr = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] cmd = '0;
  logic       timerOut, tcFlag;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sqw_timer i_sqw_timer (
    .clk(clk), .rstN(rstN), .timerIn(timerIn), .lenLoWr(lenLoWr),
    .lenHiWr(lenHiWr), .wrData(wrData), .cmdWr(cmdWr), .cmd(cmd),
    .flagClr(flagClr), .timerOut(timerOut), .tcFlag(tcFlag)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic clkN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tinPeriod();
    timerIn = 1'b0; clkN(4);
    timerIn = 1'b1; clkN(4);
  endtask

  task automatic writeLen(int unsigned len, logic [1:0] mode);
    lenLoWr = 1'b1; wrData = len[7:0]; clkN(1);
    lenLoWr = 1'b0; lenHiWr = 1'b1; wrData = {mode, len[13:8]}; clkN(1);
    lenHiWr = 1'b0; clkN(1);
  endtask

  task automatic issue(logic [1:0] c);
    cmdWr = 1'b1; cmd = c; clkN(1);
    cmdWr = 1'b0; cmd = 2'b00; clkN(1);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; clkN(1); flagClr = 1'b0; clkN(1);
  endtask

  function automatic logic expOut(int n, logic [1:0] mode, int k);
    int p;
    if (!mode[0] && k >= n) return 1'b1;
    p = k % n;
    return mode[1] ? (p != n - 1) : (p < (n + 1) / 2);
  endfunction

  task automatic runCheck(string tag, int n, logic [1:0] mode, int kFrom, int kTo, int kOff);
    for (int k = kFrom; k <= kTo; k++) begin
      tinPeriod();
      check(tag, timerOut, expOut(n, mode, k - kOff), $sformatf("out after edge %0d", k));
    end
  endtask

  task automatic settle();
    issue(2'b01);
    clearFlag();
  endtask

  task automatic t_reset();
    check("R13", timerOut, 1'b1, "out after reset");
    check("R13", tcFlag, 1'b0, "flag after reset");
    for (int k = 0; k < 4; k++) begin
      tinPeriod();
      check("R13", timerOut, 1'b1, "out without start");
    end
    check("R13", tcFlag, 1'b0, "flag without start");
  endtask

  task automatic t_start_min();
    writeLen(2, 2'b01); issue(2'b11);
    check("R2", timerOut, 1'b1, "out right after start");
    runCheck("R2", 2, 2'b01, 1, 6, 0);
    settle();
  endtask

  task automatic t_square_even();
    writeLen(4, 2'b01); issue(2'b11);
    runCheck("R5", 4, 2'b01, 1, 12, 0);
    check("R12", tcFlag, 1'b1, "flag after repeats");
    settle();
  endtask

  task automatic t_square_odd();
    writeLen(5, 2'b01); issue(2'b11);
    runCheck("R3", 5, 2'b01, 1, 15, 0);
    settle();
  endtask

  task automatic t_single_square();
    writeLen(6, 2'b00); issue(2'b11);
    runCheck("R4", 6, 2'b00, 1, 10, 0);
    check("R12", tcFlag, 1'b1, "flag set at terminal count");
    clkN(5);
    check("R12", tcFlag, 1'b1, "flag sticky");
    clearFlag();
    check("R12", tcFlag, 1'b0, "flag cleared");
    settle();
  endtask

  task automatic t_pulse_cont();
    writeLen(3, 2'b11); issue(2'b11);
    runCheck("R6", 3, 2'b11, 1, 9, 0);
    settle();
  endtask

  task automatic t_single_pulse();
    writeLen(2, 2'b10); issue(2'b11);
    runCheck("R6", 2, 2'b10, 1, 5, 0);
    settle();
  endtask

  task automatic t_wide_length();
    writeLen(258, 2'b11); issue(2'b11);
    for (int k = 1; k <= 258; k++) begin
      tinPeriod();
      if (k >= 255) check("R1", timerOut, expOut(258, 2'b11, k), $sformatf("out after edge %0d", k));
    end
    settle();
  endtask

  task automatic t_halt_now();
    writeLen(8, 2'b01); issue(2'b11);
    runCheck("R7", 8, 2'b01, 1, 3, 0);
    issue(2'b00);
    runCheck("R7", 8, 2'b01, 4, 5, 0);
    clearFlag();
    issue(2'b01);
    check("R7", timerOut, 1'b1, "out right after halt");
    for (int k = 0; k < 10; k++) begin
      tinPeriod();
      check("R7", timerOut, 1'b1, "out after halt");
    end
    check("R7", tcFlag, 1'b0, "no terminal count after halt");
    settle();
  endtask

  task automatic t_halt_at_tc();
    writeLen(4, 2'b01); issue(2'b11);
    runCheck("R8", 4, 2'b01, 1, 2, 0);
    issue(2'b10);
    runCheck("R8", 4, 2'b00, 3, 9, 0);
    check("R8", tcFlag, 1'b1, "flag at final terminal count");
    settle();
  endtask

  task automatic t_pending_start();
    writeLen(4, 2'b01); issue(2'b11);
    runCheck("R10", 4, 2'b01, 1, 1, 0);
    writeLen(6, 2'b11);
    runCheck("R10", 4, 2'b01, 2, 5, 0);
    issue(2'b11);
    runCheck("R9", 4, 2'b01, 6, 8, 0);
    runCheck("R9", 6, 2'b11, 9, 20, 8);
    settle();
  endtask

  task automatic t_short_length();
    writeLen(1, 2'b01); issue(2'b11);
    for (int k = 0; k < 6; k++) begin
      tinPeriod();
      check("R11", timerOut, 1'b1, "out with length 1");
    end
    writeLen(0, 2'b11); issue(2'b11);
    for (int k = 0; k < 4; k++) begin
      tinPeriod();
      check("R11", timerOut, 1'b1, "out with length 0");
    end
    check("R11", tcFlag, 1'b0, "no terminal count");
    settle();
  endtask

  task automatic t_steady_input();
    writeLen(4, 2'b01); issue(2'b11);
    for (int k = 0; k < 6; k++) begin
      clkN(10);
      check("R14", timerOut, 1'b1, "out with steady input");
    end
    check("R14", tcFlag, 1'b0, "flag with steady input");
    runCheck("R14", 4, 2'b01, 1, 4, 0);
    settle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    clkN(5);
    rstN = 1'b1;
    clkN(2);
    t_reset();
    t_start_min();
    t_square_even();
    t_square_odd();
    t_single_square();
    t_pulse_cont();
    t_single_pulse();
    t_wide_length();
    t_halt_now();
    t_halt_at_tc();
    t_pending_start();
    t_short_length();
    t_steady_input();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule